// File: doc/BRIEF.md
# Local Tile Histogram Equalizer

This block equalizes the intensities of one 4x4 tile of 8-bit grey pixels. A pulse on `start_i` opens a tile. The block then takes in sixteen pixels through a valid/ready stream. Each pixel goes into a short list of distinct intensities, and every entry in that list carries an occurrence counter. The list keeps itself in ascending order as it fills. A new intensity is placed at its sorted position, and every entry above that position moves up one slot in the same cycle, counter included.

When the sixteenth pixel has been taken, one cycle forms a running total of the counters. The total starts at the lowest entry and works upward. The stored tile is then replayed in arrival order. Each pixel finds its own entry by matching its intensity and reads that entry's cumulative count. The pixel is then remapped into the tile's own intensity range. The sixteen results leave as a burst of consecutive cycles, and `done_o` marks the last one.

Top module: `hist_eq_tile`

## Requirements
- R1: After reset, `in_ready_o`, `out_valid_o` and `done_o` are all low.
- R2: Pixels are accepted only while `in_ready_o` is high, and only in a cycle where `in_valid_i` is also high. Idle gaps in `in_valid_i` are allowed. `in_ready_o` rises one cycle after a `start_i` pulse seen while idle, and falls after the sixteenth accepted pixel. While idle, `in_valid_i` has no effect.
- R3: Repeated intensities share one list entry. The cumulative count used for pixel p equals the number of tile pixels whose value is less than or equal to p.
- R4: With mn and mx the smallest and largest tile values, rng = mx - mn + 1 and t = (cum * rng) >> 4. Each output equals mn when t is 0, and mn + t - 1 otherwise.
- R5: A tile whose sixteen pixels are all equal comes out unchanged.
- R6: Outputs appear in the same order in which the pixels were accepted.
- R7: The first output is valid two cycles after the clock edge that accepts the sixteenth pixel. The sixteen outputs then follow on consecutive cycles, and `out_valid_o` is low again afterwards.
- R8: `done_o` is high together with the sixteenth output and at no other time.
- R9: A `start_i` pulse while a tile is loading or emitting has no effect on that tile's results.
- R10: Pixels equal to the tile maximum map to the maximum. No output falls below the tile minimum, even when the full 0..255 range is present.
- R11: A tile of sixteen distinct intensities, which fills every list entry, is equalized correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new tile when idle |
| in_valid_i | input | 1 | Input pixel valid |
| in_pix_i | input | PIX_W | Input pixel intensity |
| in_ready_o | output | 1 | Block is accepting tile pixels |
| out_valid_o | output | 1 | Output pixel valid |
| out_pix_o | output | PIX_W | Equalized pixel |
| done_o | output | 1 | Marks the last output of the tile |

## Verification
The bench builds the block with its defaults: 8-bit pixels and a 16-pixel tile. With these values the list can be filled to all sixteen entries, and the scale reaches its widest case, a range of 256 that needs a ninth bit. Tiles with a single value, tiles with two levels and tiles with every value distinct are mixed with seeded random tiles of wide and narrow spread. Input gaps and stray start pulses are added to exercise the handshake and the idle-only start.

// File: rtl/hist_eq_pkg.sv
package hist_eq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SCAN,
    ST_EMIT
  } heq_state_e;
endpackage

// File: rtl/heq_cam_list.sv
module heq_cam_list #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             ins_en_i,
  input  logic [PIX_W-1:0] ins_pix_i,
  input  logic             latch_i,
  input  logic [PIX_W-1:0] qry_pix_i,
  output logic [CNT_W-1:0] qry_cum_o,
  output logic [CNT_W-1:0] tot_o,
  output logic [PIX_W-1:0] min_o,
  output logic [PIX_W-1:0] max_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [PIX_W-1:0] val_q   [DEPTH];
  logic [CNT_W-1:0] cnt_q   [DEPTH];
  logic [CNT_W-1:0] cum_q   [DEPTH];
  logic             vld_q   [DEPTH];
  logic [PIX_W-1:0] src_val [DEPTH];
  logic [CNT_W-1:0] src_cnt [DEPTH];
  logic             src_vld [DEPTH];
  logic [CNT_W-1:0] cum_c   [DEPTH];
  logic [DEPTH-1:0] match, below, prev_below, vld_vec;
  logic             hit;

  assign hit = |match;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign match[k]   = vld_q[k] && (val_q[k] == ins_pix_i);
    assign below[k]   = vld_q[k] && (val_q[k] < ins_pix_i);
    assign vld_vec[k] = vld_q[k];
    if (k == 0) begin : g_base
      assign prev_below[k] = 1'b1;
      assign src_val[k]    = '0;
      assign src_cnt[k]    = '0;
      assign src_vld[k]    = 1'b0;
      assign cum_c[k]      = cnt_q[k];
    end else begin : g_up
      assign prev_below[k] = below[k-1];
      assign src_val[k]    = val_q[k-1];
      assign src_cnt[k]    = cnt_q[k-1];
      assign src_vld[k]    = vld_q[k-1];
      assign cum_c[k]      = cum_c[k-1] + cnt_q[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[k] <= '0;
        cnt_q[k] <= '0;
        vld_q[k] <= 1'b0;
        cum_q[k] <= '0;
      end else begin
        if (clear_i) begin
          vld_q[k] <= 1'b0;
          cnt_q[k] <= '0;
        end else if (ins_en_i) begin
          if (hit) begin
            if (match[k]) cnt_q[k] <= cnt_q[k] + CNT_ONE;
          end else if (!below[k]) begin
            if (prev_below[k]) begin
              // insertion slot
              val_q[k] <= ins_pix_i;
              cnt_q[k] <= CNT_ONE;
              vld_q[k] <= 1'b1;
            end else begin
              // shift up one slot
              val_q[k] <= src_val[k];
              cnt_q[k] <= src_cnt[k];
              vld_q[k] <= src_vld[k];
            end
          end
        end
        if (latch_i) cum_q[k] <= cum_c[k];
      end
    end
  end

  assign tot_o = cum_c[DEPTH-1];
  assign min_o = val_q[0];

  always_comb begin
    max_o = val_q[0];
    for (int k = 0; k < DEPTH; k++)
      if (vld_q[k]) max_o = val_q[k];
  end

  always_comb begin
    qry_cum_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (vld_q[k] && val_q[k] == qry_pix_i) qry_cum_o = cum_q[k];
  end

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_chk
    // R3
    sorted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[k+1] |-> (vld_q[k] && val_q[k] < val_q[k+1]));
  end

  // R3
  new_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_en_i && !clear_i && !hit) |=> ($countones(vld_vec) == $countones($past(vld_vec)) + 1));

  // R3
  repeat_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_en_i && !clear_i && hit) |=> $stable(vld_vec));
endmodule

// File: rtl/heq_remap.sv
module heq_remap #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 5,
  parameter int SHIFT = 4
) (
  input  logic [PIX_W-1:0] min_i,
  input  logic [PIX_W-1:0] max_i,
  input  logic [CNT_W-1:0] cum_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam int PW = PIX_W + 1 + CNT_W;
  localparam logic [PIX_W:0] ONE = 1;

  logic [PIX_W:0] rng, t_w, sum;
  logic [PW-1:0]  prod, shf;

  assign rng  = {1'b0, max_i} - {1'b0, min_i} + ONE;
  assign prod = {{CNT_W{1'b0}}, rng} * {{(PIX_W+1){1'b0}}, cum_i};
  assign shf  = prod >> SHIFT;
  assign t_w  = shf[PIX_W:0];
  assign sum  = {1'b0, min_i} + t_w - ONE;
  // clamp at the tile minimum
  assign pix_o = (t_w == '0) ? min_i : sum[PIX_W-1:0];
endmodule

// File: rtl/heq_pix_buf.sv
module heq_pix_buf #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PIX_W-1:0] wr_pix_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PIX_W-1:0] rd_pix_o
);
  logic [PIX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i)
    if (wr_en_i) mem_q[wr_idx_i] <= wr_pix_i;

  assign rd_pix_o = mem_q[rd_idx_i];
endmodule

// File: rtl/hist_eq_tile.sv
module hist_eq_tile
  import hist_eq_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int TILE_N = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             in_valid_i,
  input  logic [PIX_W-1:0] in_pix_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_pix_o,
  output logic             done_o
);
  localparam int IDX_W = $clog2(TILE_N);
  localparam int CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TILE_N - 1);
  localparam logic [IDX_W-1:0] IDX_ONE = 1;
  localparam logic [CNT_W-1:0] TOT = CNT_W'(TILE_N);

  heq_state_e       state_q;
  logic [IDX_W-1:0] in_idx_q, out_idx_q;
  logic             accept, clear, latch, emit;
  logic [PIX_W-1:0] rd_pix, min_v, max_v, map_pix;
  logic [CNT_W-1:0] qry_cum, tot;
  logic             out_valid_q, done_q;
  logic [PIX_W-1:0] out_pix_q;

  assign in_ready_o = (state_q == ST_LOAD);
  assign accept     = in_ready_o && in_valid_i;
  assign clear      = (state_q == ST_IDLE) && start_i;
  assign latch      = (state_q == ST_SCAN);
  assign emit       = (state_q == ST_EMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      in_idx_q  <= '0;
      out_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_LOAD;
          in_idx_q <= '0;
        end
        ST_LOAD: if (in_valid_i) begin
          in_idx_q <= in_idx_q + IDX_ONE;
          if (in_idx_q == LAST) state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          state_q   <= ST_EMIT;
          out_idx_q <= '0;
        end
        ST_EMIT: begin
          out_idx_q <= out_idx_q + IDX_ONE;
          if (out_idx_q == LAST) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  heq_pix_buf #(.PIX_W(PIX_W), .DEPTH(TILE_N)) u_buf (
    .clk_i    (clk_i),
    .wr_en_i  (accept),
    .wr_idx_i (in_idx_q),
    .wr_pix_i (in_pix_i),
    .rd_idx_i (out_idx_q),
    .rd_pix_o (rd_pix)
  );

  heq_cam_list #(.PIX_W(PIX_W), .DEPTH(TILE_N)) u_cam (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .ins_en_i  (accept),
    .ins_pix_i (in_pix_i),
    .latch_i   (latch),
    .qry_pix_i (rd_pix),
    .qry_cum_o (qry_cum),
    .tot_o     (tot),
    .min_o     (min_v),
    .max_o     (max_v)
  );

  heq_remap #(.PIX_W(PIX_W), .CNT_W(CNT_W), .SHIFT(IDX_W)) u_map (
    .min_i (min_v),
    .max_i (max_v),
    .cum_i (qry_cum),
    .pix_o (map_pix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_pix_q   <= '0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= emit;
      done_q      <= emit && (out_idx_q == LAST);
      if (emit) out_pix_q <= map_pix;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_pix_o   = out_pix_q;
  assign done_o      = done_q;

  // R8
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> out_valid_o);

  // R10
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_pix_o >= min_v && out_pix_o <= max_v));

  // R3
  total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |-> (tot == TOT));

  // R2
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> ##2 out_valid_o);
endmodule

// File: tb/hist_eq_tile_tb.sv
module hist_eq_tile_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       in_valid_i = 1'b0;
  logic [7:0] in_pix_i = '0;
  logic       in_ready_o, out_valid_o, done_o;
  logic [7:0] out_pix_o;

  int tests = 0;
  int fails = 0;
  logic [7:0] tile_px [16];

  always #5 clk_i = ~clk_i;

  hist_eq_tile u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .in_pix_i    (in_pix_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_pix_o   (out_pix_o),
    .done_o      (done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_px(input int idx);
    int mn, mx, cum, rng, t;
    mn = 255; mx = 0; cum = 0;
    for (int i = 0; i < 16; i++) begin
      if (tile_px[i] < mn) mn = tile_px[i];
      if (tile_px[i] > mx) mx = tile_px[i];
      if (tile_px[i] <= tile_px[idx]) cum++;
    end
    rng = mx - mn + 1;
    t = (cum * rng) >> 4;
    return (t == 0) ? 8'(mn) : 8'(mn + t - 1);
  endfunction

  // gaps: random idle cycles between pixels; stray: start pulses mid-tile
  task automatic run_tile(input bit gaps, input bit stray, input string req);
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(in_ready_o === 1'b1, "R2 ready after start", int'(in_ready_o), 1);
    for (int i = 0; i < 16; i++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int j = 0; j < g; j++) begin
          in_valid_i = 1'b0; in_pix_i = 8'($urandom);
          @(negedge clk_i);
        end
      end
      in_valid_i = 1'b1; in_pix_i = tile_px[i];
      start_i = stray && (i == 5);
      @(negedge clk_i);
    end
    in_valid_i = 1'b0; start_i = 1'b0;
    chk(in_ready_o === 1'b0, "R2 ready drops", int'(in_ready_o), 0);
    chk(out_valid_o === 1'b0, "R7 no output in scan", int'(out_valid_o), 0);
    start_i = stray;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(out_valid_o === 1'b0, "R7 no output yet", int'(out_valid_o), 0);
    @(negedge clk_i);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] e;
      e = ref_px(i);
      chk(out_valid_o === 1'b1, "R7 output valid burst", int'(out_valid_o), 1);
      chk(out_pix_o === e, req, int'(out_pix_o), int'(e));
      chk(done_o === (i == 15), "R8 done position", int'(done_o), int'(i == 15));
      if (i == 8 && stray) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    chk(out_valid_o === 1'b0, "R7 burst ends", int'(out_valid_o), 0);
    chk(done_o === 1'b0, "R8 done clear", int'(done_o), 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    // R1
    chk(in_ready_o === 1'b0, "R1 ready in reset", int'(in_ready_o), 0);
    chk(out_valid_o === 1'b0, "R1 valid in reset", int'(out_valid_o), 0);
    chk(done_o === 1'b0, "R1 done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o === 1'b0, "R1 idle after reset", int'(in_ready_o), 0);

    // R2: valid while idle is ignored
    in_valid_i = 1'b1; in_pix_i = 8'd77;
    repeat (4) begin
      @(negedge clk_i);
      chk(in_ready_o === 1'b0 && out_valid_o === 1'b0, "R2 idle ignores valid",
          int'(out_valid_o), 0);
    end
    in_valid_i = 1'b0;

    // R5 constant tile
    for (int i = 0; i < 16; i++) tile_px[i] = 8'd93;
    run_tile(1'b0, 1'b0, "R5 constant tile");

    // R11 sixteen distinct, scrambled
    for (int i = 0; i < 16; i++) tile_px[i] = 8'((i * 7) % 16 * 13 + 4);
    run_tile(1'b0, 1'b0, "R11 distinct tile");

    // R10 full range with extremes
    for (int i = 0; i < 16; i++) tile_px[i] = (i % 3 == 0) ? 8'd255 : 8'(i * 5);
    tile_px[7] = 8'd0;
    run_tile(1'b1, 1'b0, "R10 full range");

    // R3 two levels
    for (int i = 0; i < 16; i++) tile_px[i] = (i < 3) ? 8'd10 : 8'd200;
    run_tile(1'b0, 1'b0, "R3 two levels");

    // R9 stray starts
    for (int i = 0; i < 16; i++) tile_px[i] = 8'($urandom);
    run_tile(1'b1, 1'b1, "R9 start while busy");

    // R4 R6 random tiles, wide and narrow spread
    for (int n = 0; n < 24; n++) begin
      int base = $urandom_range(0, 200);
      for (int i = 0; i < 16; i++)
        tile_px[i] = (n % 2 == 0) ? 8'($urandom) : 8'(base + $urandom_range(0, 9));
      run_tile(n % 3 == 0, 1'b0, "R4 R6 random tile order and value");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule